// File: doc/BRIEF.md
# Write Protect Register Controller

This block sits beside the serial command engine of a 16-bit-word serial EEPROM and decides whether each decoded instruction may change the array or the protection settings. It holds a protection boundary (the lowest protected word address), a flag that tells whether the boundary is in force, and a one-time lock bit. Every word whose address is at or above the boundary refuses writes. The engine gives the block one strobe per fully received instruction, along with the opcode, the address field, the two control pin levels and its own write-enable latch. One cycle later the block returns a verdict. The verdict says whether the instruction was accepted and whether it starts a self-timed program cycle, so the engine knows whether to report busy.

Changes to the boundary follow a strict sequence. Memory writes must first be enabled in the engine. Then an authorize instruction must be accepted. The boundary change must come as the very next instruction. Once the lock bit is set, the boundary and the flag are frozen. Instructions that would change them are then refused and start no busy period. The engine shifts out the block's 9-bit readback word after a leading dummy zero: the 8 boundary bits, most significant first, then the flag.

The boundary, flag and lock model non-volatile storage. They survive the engine's soft reset and return to their erased values only on a dedicated test reset.

Top module: `wp_guard`

## Requirements
- R1: A word write (protect pin low, opcode 01) is accepted only when the write-enable latch and the write pin are both high and its address is below the boundary. An accepted word write reports busy.
- R2: A four-word page write (protect pin low, opcode 11) covers the aligned group sharing the upper address bits. It is refused entirely if the top word of that group is at or above the boundary, even when the start address is below it.
- R3: A fill-all write (protect pin low, opcode 00, address bits 7:6 = 01) is accepted only while the flag reads 1, with the latch and write pin high.
- R4: A refused instruction returns ok=0 and busy=0. Busy is never reported without ok.
- R5: The authorize instruction (protect pin high, opcode 00, address bits 7:6 = 11) is accepted only when the latch and the write pin are high. It never changes the boundary or the flag, and it reports no busy.
- R6: Boundary write, boundary clear and lock are accepted only when the previous strobe was an accepted authorize. Any other strobe in between, accepted or not, withdraws the authorization. These three also need the write pin high.
- R7: Boundary write (protect pin high, opcode 01) loads the address and sets the flag to 0. Boundary clear (protect pin high, opcode 11, address FFh) loads all ones and sets the flag to 1. Both report busy when accepted.
- R8: Lock (protect pin high, opcode 00, address 00h), when accepted, sets the lock bit, which stays set. While it is set, boundary write, clear and lock are refused with no busy and no change.
- R9: The readback word has the boundary in bits 8:1 and the flag in bit 0. A boundary read (protect pin high, opcode 10) is always accepted, reports no busy and changes nothing.
- R10: The soft reset clears only the authorization. The test reset sets the boundary to FFh and the flag to 1, and clears the lock and the authorization.
- R11: An array read (protect pin low, opcode 10) is always accepted with no busy. Every verdict appears on the cycle after its strobe, and resp_vld is high for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous soft reset; clears authorization and verdict outputs |
| nv_clr | input | 1 | Synchronous test reset of the non-volatile state |
| ins_vld | input | 1 | One-cycle strobe: a decoded instruction is present |
| ins_prot | input | 1 | Protect-enable pin level during the instruction |
| ins_wpin | input | 1 | Write-enable pin level during the instruction |
| wel | input | 1 | Engine's write-enable latch |
| ins_op | input | 2 | Instruction opcode |
| ins_addr | input | AW | Instruction address field |
| resp_vld | output | 1 | Verdict valid, one cycle after the strobe |
| resp_ok | output | 1 | Instruction accepted |
| resp_busy | output | 1 | Accepted instruction starts a program cycle |
| pr_rdata | output | AW+1 | Boundary in bits AW:1, flag in bit 0 |

## Verification
A wrong boundary or flag shows on pr_rdata on the cycle after the strobe that caused it. It also shows on the next write verdict near the boundary, such as an address equal to the boundary or a page whose top word crosses it. A stuck authorization shows up only when a boundary change is attempted after an intervening instruction or a soft reset. The bench therefore interleaves such instructions. A lock bit that is set wrongly or lost shows as a changed ok/busy verdict on the next boundary write or clear, and a boundary that changes under lock shows on pr_rdata.

// File: rtl/wp_pkg.sv
package wp_pkg;

    typedef enum logic [3:0] {
        K_NONE, K_RD, K_WR, K_PAGE, K_FILL, K_WEN, K_WDS,
        K_PRD, K_PREN, K_PWR, K_PCLR, K_LOCK
    } kind_e;

    typedef struct packed {
        logic ok;
        logic busy;
        logic set_auth;
        logic ld_base;
        logic ld_clear;
        logic set_lock;
    } verdict_t;

    function automatic logic is_mem_write(kind_e k);
        return (k == K_WR) || (k == K_PAGE) || (k == K_FILL);
    endfunction

endpackage

// File: rtl/wp_decode.sv
module wp_decode #(
    parameter int AW = 8
) (
    input  logic          prot,
    input  logic [1:0]    op,
    input  logic [AW-1:0] addr,
    output wp_pkg::kind_e kind
);
    import wp_pkg::*;

    logic [1:0] top2;
    assign top2 = addr[AW-1 -: 2];

    always_comb begin
        kind = K_NONE;
        if (!prot) begin
            unique case (op)
                2'b10: kind = K_RD;
                2'b01: kind = K_WR;
                2'b11: kind = K_PAGE;
                default: begin
                    if (top2 == 2'b01)      kind = K_FILL;
                    else if (top2 == 2'b11) kind = K_WEN;
                    else if (top2 == 2'b00) kind = K_WDS;
                    else                    kind = K_NONE;
                end
            endcase
        end else begin
            unique case (op)
                2'b10: kind = K_PRD;
                2'b01: kind = K_PWR;
                2'b11: kind = (&addr) ? K_PCLR : K_NONE;
                default: begin
                    if (top2 == 2'b11)   kind = K_PREN;
                    else if (addr == '0) kind = K_LOCK;
                    else                 kind = K_NONE;
                end
            endcase
        end
    end

endmodule

// File: rtl/wp_judge.sv
module wp_judge #(
    parameter int AW        = 8,
    parameter int PAGE_BITS = 2
) (
    input  wp_pkg::kind_e    kind,
    input  logic [AW-1:0]    addr,
    input  logic             wel,
    input  logic             wpin,
    input  logic [AW-1:0]    base,
    input  logic             flag,
    input  logic             lock,
    input  logic             auth,
    output wp_pkg::verdict_t v
);
    import wp_pkg::*;

    localparam logic [AW-1:0] PAGE_MASK = AW'((1 << PAGE_BITS) - 1);

    logic [AW-1:0] page_hi;
    logic          wr_en;
    logic          pr_en;

    assign page_hi = addr | PAGE_MASK;
    assign wr_en   = wel && wpin;
    assign pr_en   = auth && wpin && !lock;

    always_comb begin
        v = '0;
        unique case (kind)
            K_RD, K_PRD, K_WEN, K_WDS: v.ok = 1'b1;
            K_WR:   v.ok = wr_en && (addr < base);
            K_PAGE: v.ok = wr_en && (page_hi < base);
            K_FILL: v.ok = wr_en && flag;
            K_PREN: begin
                v.ok       = wr_en;
                v.set_auth = wr_en;
            end
            K_PWR: begin
                v.ok      = pr_en;
                v.ld_base = pr_en;
            end
            K_PCLR: begin
                v.ok       = pr_en;
                v.ld_clear = pr_en;
            end
            K_LOCK: begin
                v.ok       = pr_en;
                v.set_lock = pr_en;
            end
            default: v.ok = 1'b0;
        endcase
        v.busy = v.ok && (is_mem_write(kind) || kind == K_PWR ||
                          kind == K_PCLR || kind == K_LOCK);
    end

endmodule

// File: rtl/wp_store.sv
module wp_store #(
    parameter int AW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             nv_clr,
    input  logic             upd,
    input  logic [AW-1:0]    addr,
    input  wp_pkg::verdict_t v,
    output logic [AW-1:0]    base_q,
    output logic             flag_q,
    output logic             lock_q,
    output logic             auth_q
);
    // Boundary, flag and lock: only the test reset touches them.
    always_ff @(posedge clk) begin
        if (nv_clr) begin
            base_q <= '1;
            flag_q <= 1'b1;
            lock_q <= 1'b0;
        end else if (upd) begin
            if (v.ld_base) begin
                base_q <= addr;
                flag_q <= 1'b0;
            end else if (v.ld_clear) begin
                base_q <= '1;
                flag_q <= 1'b1;
            end
            if (v.set_lock) lock_q <= 1'b1;
        end
    end

    // Authorization lasts exactly one following strobe.
    always_ff @(posedge clk) begin
        if (nv_clr || rst)
            auth_q <= 1'b0;
        else if (upd)
            auth_q <= v.set_auth;
    end

endmodule

// File: rtl/wp_guard.sv
module wp_guard #(
    parameter int AW        = 8,
    parameter int PAGE_BITS = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          nv_clr,
    input  logic          ins_vld,
    input  logic          ins_prot,
    input  logic          ins_wpin,
    input  logic          wel,
    input  logic [1:0]    ins_op,
    input  logic [AW-1:0] ins_addr,
    output logic          resp_vld,
    output logic          resp_ok,
    output logic          resp_busy,
    output logic [AW:0]   pr_rdata
);
    import wp_pkg::*;

    kind_e         kind;
    verdict_t      verd;
    logic [AW-1:0] base_q;
    logic          flag_q;
    logic          lock_q;
    logic          auth_q;

    wp_decode #(.AW(AW)) u_dec (
        .prot (ins_prot),
        .op   (ins_op),
        .addr (ins_addr),
        .kind (kind)
    );

    wp_judge #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_judge (
        .kind (kind),
        .addr (ins_addr),
        .wel  (wel),
        .wpin (ins_wpin),
        .base (base_q),
        .flag (flag_q),
        .lock (lock_q),
        .auth (auth_q),
        .v    (verd)
    );

    wp_store #(.AW(AW)) u_store (
        .clk    (clk),
        .rst    (rst),
        .nv_clr (nv_clr),
        .upd    (ins_vld),
        .addr   (ins_addr),
        .v      (verd),
        .base_q (base_q),
        .flag_q (flag_q),
        .lock_q (lock_q),
        .auth_q (auth_q)
    );

    always_ff @(posedge clk) begin
        if (rst || nv_clr) begin
            resp_vld  <= 1'b0;
            resp_ok   <= 1'b0;
            resp_busy <= 1'b0;
        end else begin
            resp_vld  <= ins_vld;
            resp_ok   <= ins_vld && verd.ok;
            resp_busy <= ins_vld && verd.busy;
        end
    end

    assign pr_rdata = {base_q, flag_q};

endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk #(
    parameter int AW        = 8,
    parameter int PAGE_BITS = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          nv_clr,
    input logic          ins_vld,
    input logic          ins_prot,
    input logic [1:0]    ins_op,
    input logic [AW-1:0] ins_addr,
    input logic          resp_vld,
    input logic          resp_ok,
    input logic          resp_busy,
    input logic [AW:0]   pr_rdata,
    input logic          lock_q
);
    localparam logic [AW-1:0] PMASK = AW'((1 << PAGE_BITS) - 1);

    assert_busy_needs_ok_R4: assert property (@(posedge clk) disable iff (rst || nv_clr)
        resp_busy |-> resp_ok);

    assert_resp_follows_R11: assert property (@(posedge clk) disable iff (rst || nv_clr)
        ins_vld |=> resp_vld);

    assert_resp_single_R11: assert property (@(posedge clk) disable iff (rst || nv_clr)
        !ins_vld |=> !resp_vld);

    assert_wr_denied_R1: assert property (@(posedge clk) disable iff (rst || nv_clr)
        (ins_vld && !ins_prot && ins_op == 2'b01 && ins_addr >= pr_rdata[AW:1])
        |=> (!resp_ok && !resp_busy));

    assert_page_denied_R2: assert property (@(posedge clk) disable iff (rst || nv_clr)
        (ins_vld && !ins_prot && ins_op == 2'b11 && (ins_addr | PMASK) >= pr_rdata[AW:1])
        |=> !resp_ok);

    assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (nv_clr)
        lock_q |=> lock_q);

    assert_locked_nobusy_R8: assert property (@(posedge clk) disable iff (rst || nv_clr)
        (ins_vld && ins_prot && lock_q) |=> !resp_busy);

    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (nv_clr)
        !ins_vld |=> $stable(pr_rdata));

endmodule

bind wp_guard wp_guard_chk #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .nv_clr    (nv_clr),
    .ins_vld   (ins_vld),
    .ins_prot  (ins_prot),
    .ins_op    (ins_op),
    .ins_addr  (ins_addr),
    .resp_vld  (resp_vld),
    .resp_ok   (resp_ok),
    .resp_busy (resp_busy),
    .pr_rdata  (pr_rdata),
    .lock_q    (lock_q)
);

// File: tb/tb_wp_guard.sv
`timescale 1ns/1ps
module tb_wp_guard;
    localparam int AW = 8;
    localparam int NV = 38;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          nv_clr = 1'b1;
    logic          ins_vld = 1'b0;
    logic          ins_prot = 1'b0;
    logic          ins_wpin = 1'b0;
    logic          wel = 1'b0;
    logic [1:0]    ins_op = 2'b00;
    logic [AW-1:0] ins_addr = '0;
    logic          resp_vld, resp_ok, resp_busy;
    logic [AW:0]   pr_rdata;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    wp_guard #(.AW(AW), .PAGE_BITS(2)) dut (
        .clk(clk), .rst(rst), .nv_clr(nv_clr), .ins_vld(ins_vld),
        .ins_prot(ins_prot), .ins_wpin(ins_wpin), .wel(wel),
        .ins_op(ins_op), .ins_addr(ins_addr), .resp_vld(resp_vld),
        .resp_ok(resp_ok), .resp_busy(resp_busy), .pr_rdata(pr_rdata)
    );

    // {prot, wpin, wel, op[2], addr[8], ok, busy, rdata[9], req[4]}
    localparam logic [27:0] VEC [NV] = '{
        {1'b0,1'b0,1'b0,2'b10,8'h05,1'b1,1'b0,9'h1FF,4'd11}, // R11 array read
        {1'b0,1'b1,1'b0,2'b01,8'h10,1'b0,1'b0,9'h1FF,4'd1},  // R1 latch low
        {1'b0,1'b1,1'b1,2'b01,8'h10,1'b1,1'b1,9'h1FF,4'd1},  // R1 accepted
        {1'b0,1'b1,1'b1,2'b01,8'hFF,1'b0,1'b0,9'h1FF,4'd4},  // R4 at boundary
        {1'b0,1'b1,1'b1,2'b00,8'h40,1'b1,1'b1,9'h1FF,4'd3},  // R3 flag=1
        {1'b1,1'b1,1'b1,2'b01,8'h20,1'b0,1'b0,9'h1FF,4'd6},  // R6 no authorize
        {1'b1,1'b1,1'b0,2'b00,8'hC0,1'b0,1'b0,9'h1FF,4'd5},  // R5 latch low
        {1'b1,1'b1,1'b1,2'b00,8'hC0,1'b1,1'b0,9'h1FF,4'd5},  // R5
        {1'b1,1'b1,1'b1,2'b01,8'h20,1'b1,1'b1,9'h040,4'd7},  // R7 write 20h
        {1'b0,1'b1,1'b1,2'b01,8'h1F,1'b1,1'b1,9'h040,4'd1},  // R1 just below
        {1'b0,1'b1,1'b1,2'b01,8'h20,1'b0,1'b0,9'h040,4'd4},  // R4 equal
        {1'b0,1'b1,1'b1,2'b11,8'h1C,1'b1,1'b1,9'h040,4'd2},  // R2 page below
        {1'b0,1'b1,1'b1,2'b11,8'h20,1'b0,1'b0,9'h040,4'd2},  // R2 page inside
        {1'b0,1'b1,1'b1,2'b00,8'h40,1'b0,1'b0,9'h040,4'd3},  // R3 flag=0
        {1'b1,1'b1,1'b1,2'b00,8'hC0,1'b1,1'b0,9'h040,4'd5},  // R5
        {1'b0,1'b0,1'b0,2'b10,8'h00,1'b1,1'b0,9'h040,4'd11}, // R11 read between
        {1'b1,1'b1,1'b1,2'b01,8'h22,1'b0,1'b0,9'h040,4'd6},  // R6 cancelled
        {1'b1,1'b1,1'b1,2'b00,8'hC0,1'b1,1'b0,9'h040,4'd5},  // R5
        {1'b1,1'b0,1'b1,2'b01,8'h22,1'b0,1'b0,9'h040,4'd6},  // R6 write pin low
        {1'b1,1'b1,1'b1,2'b00,8'hC0,1'b1,1'b0,9'h040,4'd5},  // R5
        {1'b1,1'b1,1'b1,2'b01,8'h22,1'b1,1'b1,9'h044,4'd7},  // R7 write 22h
        {1'b0,1'b1,1'b1,2'b11,8'h1D,1'b1,1'b1,9'h044,4'd2},  // R2 group 1C..1F
        {1'b0,1'b1,1'b1,2'b11,8'h21,1'b0,1'b0,9'h044,4'd2},  // R2 group crosses
        {1'b1,1'b0,1'b0,2'b10,8'h00,1'b1,1'b0,9'h044,4'd9},  // R9 boundary read
        {1'b1,1'b1,1'b1,2'b00,8'hC0,1'b1,1'b0,9'h044,4'd5},  // R5 flag kept 0
        {1'b1,1'b1,1'b1,2'b11,8'hFF,1'b1,1'b1,9'h1FF,4'd7},  // R7 clear
        {1'b1,1'b1,1'b1,2'b00,8'hC0,1'b1,1'b0,9'h1FF,4'd5},  // R5
        {1'b1,1'b1,1'b1,2'b11,8'h7F,1'b0,1'b0,9'h1FF,4'd7},  // R7 bad clear addr
        {1'b1,1'b1,1'b1,2'b00,8'hC0,1'b1,1'b0,9'h1FF,4'd5},  // R5
        {1'b1,1'b1,1'b1,2'b01,8'h30,1'b1,1'b1,9'h060,4'd7},  // R7 write 30h
        {1'b1,1'b1,1'b1,2'b00,8'hC0,1'b1,1'b0,9'h060,4'd5},  // R5
        {1'b1,1'b1,1'b1,2'b00,8'h00,1'b1,1'b1,9'h060,4'd8},  // R8 lock
        {1'b1,1'b1,1'b1,2'b00,8'hC0,1'b1,1'b0,9'h060,4'd5},  // R5 still taken
        {1'b1,1'b1,1'b1,2'b01,8'h10,1'b0,1'b0,9'h060,4'd8},  // R8 write frozen
        {1'b1,1'b1,1'b1,2'b00,8'hC0,1'b1,1'b0,9'h060,4'd5},  // R5
        {1'b1,1'b1,1'b1,2'b11,8'hFF,1'b0,1'b0,9'h060,4'd8},  // R8 clear frozen
        {1'b1,1'b1,1'b1,2'b00,8'hC0,1'b1,1'b0,9'h060,4'd5},  // R5
        {1'b1,1'b1,1'b1,2'b00,8'h00,1'b0,1'b0,9'h060,4'd8}   // R8 relock
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic p, input logic w, input logic e,
                        input logic [1:0] op, input logic [7:0] a);
        ins_prot = p; ins_wpin = w; wel = e; ins_op = op; ins_addr = a;
        ins_vld = 1'b1;
        @(negedge clk);
        ins_vld = 1'b0;
    endtask

    task automatic pulse_rst(input logic nv);
        if (nv) nv_clr = 1'b1; else rst = 1'b1;
        @(negedge clk);
        nv_clr = 1'b0; rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0; nv_clr = 1'b0;
        // R10 reset state
        chk("R10 reset rdata", 32'(pr_rdata), 32'h1FF);
        chk("R11 reset vld", 32'(resp_vld), 32'h0);
        chk("R4 reset ok", 32'(resp_ok), 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [27:0] v;
            string tag;
            v = VEC[i];
            send(v[27], v[26], v[25], v[24:23], v[22:15]);
            tag = $sformatf("R%0d vec%0d", v[3:0], i);
            chk({tag, " ok"},    32'(resp_ok),   32'(v[14]));
            chk({tag, " busy"},  32'(resp_busy), 32'(v[13]));
            chk({tag, " rdata"}, 32'(pr_rdata),  32'(v[12:4]));
            chk({tag, " vld"},   32'(resp_vld),  32'h1);
        end

        // R11: verdict valid lasts one cycle
        @(negedge clk);
        chk("R11 vld drops", 32'(resp_vld), 32'h0);

        // R10: soft reset keeps locked boundary
        send(1'b1, 1'b1, 1'b1, 2'b00, 8'hC0);
        pulse_rst(1'b0);
        chk("R10 soft keeps rdata", 32'(pr_rdata), 32'h060);
        send(1'b1, 1'b1, 1'b1, 2'b01, 8'h10);
        chk("R10 soft keeps lock", 32'(resp_ok), 32'h0);

        // R10: test reset restores erased state
        pulse_rst(1'b1);
        chk("R10 nv rdata", 32'(pr_rdata), 32'h1FF);
        chk("R10 nv vld", 32'(resp_vld), 32'h0);
        send(1'b1, 1'b1, 1'b1, 2'b00, 8'hC0);
        chk("R10 authorize ok", 32'(resp_ok), 32'h1);
        pulse_rst(1'b0);
        send(1'b1, 1'b1, 1'b1, 2'b01, 8'h10);
        chk("R10 soft drops authorization", 32'(resp_ok), 32'h0);
        chk("R10 rdata after refused", 32'(pr_rdata), 32'h1FF);
        send(1'b1, 1'b1, 1'b1, 2'b00, 8'hC0);
        send(1'b1, 1'b1, 1'b1, 2'b01, 8'h10);
        chk("R10 lock cleared ok", 32'(resp_ok), 32'h1);
        chk("R10 lock cleared busy", 32'(resp_busy), 32'h1);
        chk("R10 lock cleared rdata", 32'(pr_rdata), 32'h020);

        finish_run();
    end
endmodule